// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block collects six reset requests (power-on, brown-out, an external active-low pin, a software system-reset bit, a two-stage watchdog and a main-oscillator fault flag) and turns them into three kinds of reset output: one for the core, one per on-chip peripheral, and one for the debug TAP. Each source has its own reach. Power-on clears everything, the debug TAP included. Every other system source clears the core and all peripherals and leaves the TAP alone. Software can also hold any single peripheral in reset through a per-peripheral bit.

Each system reset is stretched to a minimum length and released on a clock edge. The external pin is synchronised and glitch-filtered before use. The watchdog path turns a first time-out into an interrupt and only a second one into a reset. A sticky cause register records which sources have requested a reset. Software clears its bits by writing ones, and power-on leaves only its own bit set. Voltage sensing and oscillator frequency checking happen outside the block and arrive here as synchronous digital flags.

Top module: `rstctl_top`

## Requirements
- R1: One cycle after a clock edge that samples `por_req` high, `core_rst`, every bit of `periph_rst` and `tap_rst` are 1, and `reset_cause` equals 6'b000001.
- R2: `core_rst` stays 1 for MIN_HOLD (default 16) clock edges after the last edge that sampled any system request. It falls on the next edge. A new request during the hold restarts the count.
- R3: The external pin `ext_rst_pin_n` is active low. It passes through a two-flop synchroniser and becomes a request only after FILT_LEN (default 4) consecutive low synchronised samples, so a low pulse of 3 clock cycles is ignored. A 4-cycle pulse resets the core and peripherals but not the TAP, and sets cause bit 1.
- R4: `bor_req` resets the core and peripherals, not the TAP, and sets cause bit 2.
- R5: `sw_sys_req` resets the core and peripherals, not the TAP, and sets cause bit 3.
- R6: A `wdt_timeout` pulse with `wdt_irq` at 0 sets `wdt_irq` and causes no reset. `wdt_ack` clears `wdt_irq`, but a time-out in the same cycle takes precedence. A time-out while `wdt_irq` is 1 requests a system reset and sets cause bit 4. `wdt_irq` returns to 0 the cycle after `core_rst` is seen at 1.
- R7: `osc_fail` resets the core and peripherals, not the TAP, and sets cause bit 5.
- R8: `periph_rst[i]` follows `periph_sw_rst[i]` one cycle later and affects neither `core_rst` nor any other peripheral.
- R9: Cause bits are sticky and accumulate across resets. Writing with `cause_clr_we`=1 clears every bit set in `cause_clr_mask`. A source setting a bit in the same cycle wins over the clear.
- R10: `tap_rst` rises only after an edge that sampled `por_req` high, and it is held for the same MIN_HOLD edges.
- R11: Whenever `core_rst` is 1, every bit of `periph_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, active high; also the block's own synchronous reset |
| bor_req | input | 1 | Brown-out request, active high |
| ext_rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| sw_sys_req | input | 1 | Software whole-device reset request |
| wdt_timeout | input | 1 | One-cycle watchdog time-out pulse |
| wdt_ack | input | 1 | Clears a pending first-stage watchdog interrupt |
| osc_fail | input | 1 | Main-oscillator fault flag |
| periph_sw_rst | input | NPERIPH | Per-peripheral software reset bits |
| cause_clr_we | input | 1 | Write strobe for clearing cause bits |
| cause_clr_mask | input | 6 | Write-1-to-clear mask for the cause register |
| core_rst | output | 1 | Core reset, active high |
| periph_rst | output | NPERIPH | Per-peripheral resets, active high |
| tap_rst | output | 1 | Debug TAP reset, active high |
| reset_cause | output | 6 | Sticky cause flags: bit0 power-on, bit1 pin, bit2 brown-out, bit3 software, bit4 watchdog, bit5 oscillator |
| wdt_irq | output | 1 | First-stage watchdog interrupt |

## Verification
The bench builds the block with its default parameters: MIN_HOLD=16, FILT_LEN=4, two synchroniser flops and eight peripherals. With these values the full hold window and the filter threshold fit in short stimulus runs. The 3-cycle versus 4-cycle pin pulses, a request that restarts a hold still in progress, and a power-on that lands after other causes have accumulated can all be reached directly, and each is compared on every clock against a behavioural model.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int NUM_SRC = 6;

    // bit positions inside the cause register
    typedef enum int unsigned {
        SRC_POR = 0,
        SRC_EXT = 1,
        SRC_BOR = 2,
        SRC_SW  = 3,
        SRC_WDT = 4,
        SRC_OSC = 5
    } src_e;

    typedef logic [NUM_SRC-1:0] cause_t;

    // packed so that field order equals cause bit order (MSB first)
    typedef struct packed {
        logic osc;
        logic wdt;
        logic sw;
        logic bor;
        logic ext;
        logic por;
    } req_t;

    function automatic cause_t req_to_cause(input req_t r);
        return cause_t'(r);
    endfunction

    function automatic logic any_req(input req_t r);
        return |cause_t'(r);
    endfunction

    function automatic cause_t cause_next(input cause_t cur, input logic we,
                                          input cause_t mask, input cause_t set);
        cause_t keep;
        keep = we ? (cur & ~mask) : cur;
        return keep | set;
    endfunction

endpackage

// File: rtl/rstctl_pin_filter.sv
module rstctl_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic active
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;
    logic                   synced_low;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign synced_low = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !synced_low) low_cnt <= '0;
        else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
    end

    assign active = (low_cnt == FULL);
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic req,
    output logic rst_next,
    output logic rst_q
);
    localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

    logic [CW-1:0] left;

    assign rst_next = req | (left != '0);

    always_ff @(posedge clk) begin
        if (req) begin
            left  <= LOAD;
            rst_q <= 1'b1;
        end else if (left != '0) begin
            left  <= left - 1'b1;
            rst_q <= 1'b1;
        end else begin
            rst_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rstctl_wdt_stage.sv
module rstctl_wdt_stage (
    input  logic clk,
    input  logic rst,
    input  logic sys_rst,
    input  logic timeout,
    input  logic ack,
    output logic irq,
    output logic rst_req
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst || sys_rst)         armed <= 1'b0;
        else if (timeout && !armed) armed <= 1'b1;
        else if (ack)               armed <= 1'b0;
    end

    assign irq     = armed;
    assign rst_req = timeout & armed;
endmodule

// File: rtl/rstctl_cause_reg.sv
module rstctl_cause_reg
    import rstctl_pkg::*;
(
    input  logic   clk,
    input  logic   por,
    input  cause_t set,
    input  logic   clr_we,
    input  cause_t clr_mask,
    output cause_t cause
);
    always_ff @(posedge clk) begin
        if (por) begin
            cause          <= '0;
            cause[SRC_POR] <= 1'b1;
        end else begin
            cause <= cause_next(cause, clr_we, clr_mask, set);
        end
    end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int NPERIPH     = 8,
    parameter int MIN_HOLD    = 16,
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               bor_req,
    input  logic               ext_rst_pin_n,
    input  logic               sw_sys_req,
    input  logic               wdt_timeout,
    input  logic               wdt_ack,
    input  logic               osc_fail,
    input  logic [NPERIPH-1:0] periph_sw_rst,
    input  logic               cause_clr_we,
    input  logic [NUM_SRC-1:0] cause_clr_mask,
    output logic               core_rst,
    output logic [NPERIPH-1:0] periph_rst,
    output logic               tap_rst,
    output logic [NUM_SRC-1:0] reset_cause,
    output logic               wdt_irq
);
    req_t reqs;
    req_t set_reqs;
    logic ext_active;
    logic wdt_rst;
    logic sys_any;
    logic core_next;
    logic tap_next;

    rstctl_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_pin (
        .clk    (clk),
        .rst    (por_req),
        .pin_n  (ext_rst_pin_n),
        .active (ext_active)
    );

    rstctl_wdt_stage u_wdt (
        .clk     (clk),
        .rst     (por_req),
        .sys_rst (core_rst),
        .timeout (wdt_timeout),
        .ack     (wdt_ack),
        .irq     (wdt_irq),
        .rst_req (wdt_rst)
    );

    always_comb begin
        reqs     = '{osc: osc_fail, wdt: wdt_rst, sw: sw_sys_req,
                     bor: bor_req, ext: ext_active, por: por_req};
        set_reqs = reqs;
        set_reqs.por = 1'b0;
        sys_any  = any_req(reqs);
    end

    // system domain: core and peripherals
    rstctl_stretch #(.HOLD(MIN_HOLD)) u_core_hold (
        .clk      (clk),
        .req      (sys_any),
        .rst_next (core_next),
        .rst_q    (core_rst)
    );

    // debug domain: power-on only
    rstctl_stretch #(.HOLD(MIN_HOLD)) u_tap_hold (
        .clk      (clk),
        .req      (por_req),
        .rst_next (tap_next),
        .rst_q    (tap_rst)
    );

    for (genvar g = 0; g < NPERIPH; g++) begin : g_periph
        logic lane_q;
        always_ff @(posedge clk) begin
            lane_q <= core_next | periph_sw_rst[g];
        end
        assign periph_rst[g] = lane_q;
    end

    rstctl_cause_reg u_cause (
        .clk      (clk),
        .por      (por_req),
        .set      (req_to_cause(set_reqs)),
        .clr_we   (cause_clr_we),
        .clr_mask (cause_clr_mask),
        .cause    (reset_cause)
    );

    logic unused_tap_next;
    assign unused_tap_next = tap_next;
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
    parameter int NPERIPH  = 8,
    parameter int MIN_HOLD = 16
) (
    input logic               clk,
    input logic               por_req,
    input logic               wdt_timeout,
    input logic [NPERIPH-1:0] periph_sw_rst,
    input logic               core_rst,
    input logic [NPERIPH-1:0] periph_rst,
    input logic               tap_rst,
    input logic               wdt_irq
);
    localparam int HW = $clog2(MIN_HOLD + 2);
    localparam logic [HW-1:0] SAT = HW'(MIN_HOLD);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (por_req || !core_rst) hi_cnt <= '0;
        else if (hi_cnt != SAT)   hi_cnt <= hi_cnt + 1'b1;
    end

    // R2: a released core reset had been high for at least MIN_HOLD edges
    p_min_hold_r2: assert property (@(posedge clk) disable iff (por_req)
        $fell(core_rst) |-> ($past(hi_cnt) == SAT || $past(hi_cnt) == SAT - 1'b1));

    p_tap_only_por_r10: assert property (@(posedge clk) disable iff (por_req)
        $rose(tap_rst) |-> $past(por_req));

    p_tap_implies_core_r1: assert property (@(posedge clk) disable iff (por_req)
        tap_rst |-> core_rst);

    p_core_covers_periph_r11: assert property (@(posedge clk) disable iff (por_req)
        core_rst |-> (&periph_rst));

    p_wdt_second_r6: assert property (@(posedge clk) disable iff (por_req)
        (wdt_timeout && wdt_irq && !core_rst) |=> core_rst);

    p_wdt_first_r6: assert property (@(posedge clk) disable iff (por_req)
        (wdt_timeout && !wdt_irq && !core_rst) |=> (wdt_irq && !core_rst));

    p_periph_sw_r8: assert property (@(posedge clk) disable iff (por_req)
        (periph_rst & $past(periph_sw_rst)) == $past(periph_sw_rst));
endmodule

bind rstctl_top rstctl_chk #(.NPERIPH(NPERIPH), .MIN_HOLD(MIN_HOLD)) i_chk (
    .clk           (clk),
    .por_req       (por_req),
    .wdt_timeout   (wdt_timeout),
    .periph_sw_rst (periph_sw_rst),
    .core_rst      (core_rst),
    .periph_rst    (periph_rst),
    .tap_rst       (tap_rst),
    .wdt_irq       (wdt_irq)
);

// File: tb/test_rstctl_top.sv
`timescale 1ns/1ps
module test_rstctl_top;
    localparam int NP = 8;
    localparam int HOLD = 16;

    logic clk = 1'b0;
    logic por = 1'b1, bor = 1'b0, pin_n = 1'b1, sw = 1'b0;
    logic wto = 1'b0, wack = 1'b0, osc = 1'b0, clr_we = 1'b0;
    logic [NP-1:0] psw = '0;
    logic [5:0] clr_mask = '0;
    logic core, tap, irq;
    logic [NP-1:0] per;
    logic [5:0] cause;

    int n_cmp = 0, n_bad = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    rstctl_top i_rstctl_top (
        .clk(clk), .por_req(por), .bor_req(bor), .ext_rst_pin_n(pin_n),
        .sw_sys_req(sw), .wdt_timeout(wto), .wdt_ack(wack), .osc_fail(osc),
        .periph_sw_rst(psw), .cause_clr_we(clr_we), .cause_clr_mask(clr_mask),
        .core_rst(core), .periph_rst(per), .tap_rst(tap),
        .reset_cause(cause), .wdt_irq(irq)
    );

    // behavioural reference state
    int hist[7];
    int sys_left = 0, tap_left = 0;
    bit stage = 0, m_core = 0;
    logic [5:0] m_cause = '0;
    logic [NP-1:0] m_per = '0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    initial for (int k = 0; k < 7; k++) hist[k] = 1;

    always @(posedge clk) begin
        bit ext, wrst, req;
        for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = pin_n;
        if (por) for (int k = 0; k < 7; k++) hist[k] = 1;
        ext  = (hist[3] == 0) && (hist[4] == 0) && (hist[5] == 0) && (hist[6] == 0);
        wrst = wto && stage;
        req  = por || bor || ext || sw || wrst || osc;
        if (por || m_core) stage = 0;
        else if (wto && !stage) stage = 1;
        else if (wack) stage = 0;
        if (req) sys_left = HOLD; else if (sys_left > 0) sys_left--;
        if (por) tap_left = HOLD; else if (tap_left > 0) tap_left--;
        m_core = (sys_left > 0);
        m_per  = {NP{m_core}} | psw;
        if (por) m_cause = 6'b000001;
        else begin
            if (clr_we) m_cause = m_cause & ~clr_mask;
            m_cause = m_cause | {osc, wrst, sw, bor, ext, 1'b0};
        end
        #1;
        chk("core_rst (R2)", core, m_core);
        chk("tap_rst (R10)", tap, tap_left > 0);
        chk("periph_rst (R8 R11)", per, m_per);
        chk("reset_cause (R9)", cause, m_cause);
        chk("wdt_irq (R6)", irq, stage);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pin(input int n);
        pin_n = 1'b0; cyc(n); pin_n = 1'b1;
    endtask

    initial begin
        // R1: power-on from time zero
        cyc(3); por = 1'b0; cyc(22);
        phase = "R9"; clr_we = 1'b1; clr_mask = 6'b000001; cyc(1); clr_we = 1'b0; cyc(2);
        phase = "R3"; pulse_pin(3); cyc(12);
        pulse_pin(4); cyc(30);
        pulse_pin(40); cyc(25);
        phase = "R4"; bor = 1'b1; cyc(1); bor = 1'b0; cyc(22);
        phase = "R2"; bor = 1'b1; cyc(1); bor = 1'b0; cyc(10);
        bor = 1'b1; cyc(1); bor = 1'b0; cyc(22);
        phase = "R5"; sw = 1'b1; cyc(1); sw = 1'b0; cyc(22);
        phase = "R7"; osc = 1'b1; cyc(2); osc = 1'b0; cyc(22);
        phase = "R6"; wto = 1'b1; cyc(1); wto = 1'b0; cyc(4);
        wack = 1'b1; cyc(1); wack = 1'b0; cyc(3);
        wto = 1'b1; wack = 1'b1; cyc(1); wto = 1'b0; wack = 1'b0; cyc(3);
        wto = 1'b1; cyc(1); wto = 1'b0; cyc(5);
        wto = 1'b1; cyc(2); wto = 1'b0; cyc(22);
        phase = "R8"; psw = 8'h05; cyc(4); psw = 8'hA0; cyc(3); psw = 8'h00; cyc(3);
        psw = 8'h10; sw = 1'b1; cyc(1); sw = 1'b0; cyc(20); psw = 8'h00; cyc(3);
        phase = "R9"; clr_we = 1'b1; clr_mask = 6'b111111; bor = 1'b1; cyc(1);
        bor = 1'b0; clr_we = 1'b0; cyc(20);
        clr_we = 1'b1; clr_mask = 6'b000100; cyc(1); clr_we = 1'b0; cyc(2);
        phase = "R11"; osc = 1'b1; psw = 8'h3C; cyc(1); osc = 1'b0; cyc(8); psw = 8'h00; cyc(14);
        phase = "R10"; pulse_pin(6); cyc(4); bor = 1'b1; cyc(1); bor = 1'b0; cyc(25);
        phase = "R1"; sw = 1'b1; cyc(1); sw = 1'b0; cyc(3);
        por = 1'b1; cyc(2); por = 1'b0; cyc(22);
        cyc(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule